// File: doc/BRIEF.md
# Oscillator Pair Sweep Controller

This block walks a bank of free-running ring oscillators through every pairing between two groups, so that a response can be built from their frequency races. An 8-bit challenge counter names one oscillator in the first group of 16 with its upper nibble and one in the second group of 16 with its lower nibble. For each challenge, only the two named oscillators are switched on. After a programmable settle time the controller starts a race in an external arbiter and waits for the result. It shifts the winner bit into a 256-bit response, along with a matching mask bit that marks a race the arbiter judged usable. It then drops every enable before it moves to the next challenge.

Once all 256 races are done, the controller hands the response to the host as sixteen 16-bit words on a valid/ready port. The mask travels beside each word on a parallel port. A one-cycle done pulse closes the transfer. A start request made while a sweep or transfer is in progress has no effect.

Top module: `pair_sweep_ctrl`

## Requirements
- R1: After reset, and while idle, `osc_en_o` is all zero, and `race_go_o`, `word_valid_o` and `done_o` are low.
- R2: The challenge is 8 bits wide. Bits 7:4 select `osc_en_o[bits 7:4]` in group one, and bits 3:0 select `osc_en_o[16 + bits 3:0]` in group two. A sweep issues exactly one race for each challenge, from 0 up to 255 in increasing order.
- R3: Whenever any enable is high, exactly one bit of `osc_en_o[15:0]` is high and exactly one bit of `osc_en_o[31:16]` is high. All other 30 enables are low.
- R4: `race_go_o` rises exactly `settle_cycles_i + 2` clock cycles after the pair's enables rise.
- R5: Between two races, `race_go_o` and all of `osc_en_o` are low for at least one cycle before a different pair is enabled.
- R6: A race ends in the cycle in which `race_done_i` is high while `race_go_o` is high. `race_go_o` is low in the next cycle, and the `race_win_i` value of that cycle becomes response bit c for challenge c.
- R7: The `race_valid_i` value of the same cycle becomes mask bit c. A tied race (valid 0) is therefore recorded as 0 in the mask.
- R8: The response goes out as 16 words in increasing order. Word w carries response bits 16w to 16w+15 on `word_data_o` and the matching mask bits on `word_mask_o`, with bit 0 holding challenge 16w. While `word_valid_o` is high and `word_ready_i` is low, the word and mask hold steady.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last word is accepted. `word_valid_o` is low from that cycle on.
- R10: `start_i` has no effect unless the block is idle. A pulse during a sweep neither restarts nor disturbs the challenge order.
- R11: While words are being offered, no oscillator is enabled and `race_go_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep when idle |
| settle_cycles_i | input | 8 | Extra settle cycles before each race |
| osc_en_o | output | 32 | Per-oscillator enables; [15:0] group one, [31:16] group two |
| race_go_o | output | 1 | Race enable to the arbiter |
| race_done_i | input | 1 | Arbiter has a result |
| race_win_i | input | 1 | 1 when the group-one oscillator won |
| race_valid_i | input | 1 | Result is usable (not a tie) |
| word_valid_o | output | 1 | Response word offered |
| word_ready_i | input | 1 | Host accepts the word |
| word_data_o | output | 16 | Response word |
| word_mask_o | output | 16 | Validity mask for the word |
| done_o | output | 1 | One-cycle pulse after the last word |

## Verification
The settle window is due `settle_cycles_i + 2` cycles after the enables rise. The bench's arbiter model counts falling edges that see enables on and `race_go_o` off, and compares that count at the first falling edge where the race enable is seen. A race result driven at a falling edge is taken at the next rising edge, so the enables and race enable are seen low at the falling edge after that. Each word is sampled at the falling edge after `word_valid_o` rises and is rechecked while ready is held low. `done_o` is checked at the falling edge right after the accepting rising edge, and again one cycle later, when it must have dropped.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETTLE,
    ST_RACE,
    ST_CAPTURE,
    ST_NEXT,
    ST_OUTPUT
  } psc_state_e;
endpackage

// File: rtl/psc_pair_decode.sv
module psc_pair_decode #(
  parameter int SEL_W = 4
) (
  input  logic [2*SEL_W-1:0]          chal_i,
  input  logic                        active_i,
  output logic [2*(1<<SEL_W)-1:0]     en_o
);
  localparam int GRP = 1 << SEL_W;

  logic [SEL_W-1:0] sel_a;
  logic [SEL_W-1:0] sel_b;

  assign sel_a = chal_i[2*SEL_W-1:SEL_W];
  assign sel_b = chal_i[SEL_W-1:0];

  for (genvar g = 0; g < GRP; g++) begin : g_osc
    assign en_o[g]       = active_i && (sel_a == SEL_W'(g));
    assign en_o[GRP + g] = active_i && (sel_b == SEL_W'(g));
  end
endmodule

// File: rtl/psc_settle_timer.sv
module psc_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i || (run_i && !expired_o);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psc_resp_store.sv
module psc_resp_store #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic              cap_bit_i,
  input  logic              cap_ok_i,
  input  logic              pop_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] mask_o
);
  localparam int NLANE = 2;

  logic [NLANE-1:0] lane_in;
  logic [WORD_W-1:0] lane_word [NLANE];

  assign lane_in = {cap_ok_i, cap_bit_i};

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] sr_d;
    logic             sr_en;

    assign sr_en = cap_en_i || pop_en_i;

    always_comb begin
      if (cap_en_i) sr_d = {lane_in[l], sr_q[DEPTH-1:1]};
      else          sr_d = {{WORD_W{1'b0}}, sr_q[DEPTH-1:WORD_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (sr_en) sr_q <= sr_d;
    end

    assign lane_word[l] = sr_q[WORD_W-1:0];
  end

  assign word_o = lane_word[0];
  assign mask_o = lane_word[1];
endmodule

// File: rtl/pair_sweep_ctrl.sv
module pair_sweep_ctrl
  import psc_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int WORD_W   = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [SETTLE_W-1:0]       settle_cycles_i,
  output logic [2*(1<<SEL_W)-1:0]   osc_en_o,
  output logic                      race_go_o,
  input  logic                      race_done_i,
  input  logic                      race_win_i,
  input  logic                      race_valid_i,
  output logic                      word_valid_o,
  input  logic                      word_ready_i,
  output logic [WORD_W-1:0]         word_data_o,
  output logic [WORD_W-1:0]         word_mask_o,
  output logic                      done_o
);
  localparam int CHAL_W = 2 * SEL_W;
  localparam int NPAIR  = 1 << CHAL_W;
  localparam int NWORD  = NPAIR / WORD_W;
  localparam int WIDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;

  psc_state_e         state_q, state_d;
  logic [CHAL_W-1:0]  chal_q, chal_d;
  logic [WIDX_W-1:0]  widx_q, widx_d;
  logic               done_q;
  logic               chal_en, widx_en;
  logic               last_chal, last_word;
  logic               pair_on, cap_en, pop_en, accept_start;
  logic               settle_over;

  assign last_chal    = (chal_q == CHAL_W'(NPAIR - 1));
  assign last_word    = (widx_q == WIDX_W'(NWORD - 1));
  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign pair_on      = (state_q == ST_SELECT) || (state_q == ST_SETTLE) ||
                        (state_q == ST_RACE);
  assign cap_en       = (state_q == ST_RACE) && race_done_i;
  assign pop_en       = (state_q == ST_OUTPUT) && word_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SELECT;
      ST_SELECT:  state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_over) state_d = ST_RACE;
      ST_RACE:    if (race_done_i) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_NEXT;
      ST_NEXT:    state_d = last_chal ? ST_OUTPUT : ST_SELECT;
      ST_OUTPUT:  if (word_ready_i && last_word) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    chal_en = accept_start || (state_q == ST_NEXT);
    chal_d  = accept_start ? '0 : chal_q + CHAL_W'(1);
    widx_en = accept_start || pop_en;
    widx_d  = accept_start ? '0 : widx_q + WIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chal_q  <= '0;
      widx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= pop_en && last_word;
      if (chal_en) chal_q <= chal_d;
      if (widx_en) widx_q <= widx_d;
    end
  end

  psc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (state_q == ST_SELECT),
    .load_val_i (settle_cycles_i),
    .run_i      (state_q == ST_SETTLE),
    .expired_o  (settle_over)
  );

  psc_pair_decode #(.SEL_W(SEL_W)) u_decode (
    .chal_i   (chal_q),
    .active_i (pair_on),
    .en_o     (osc_en_o)
  );

  psc_resp_store #(.DEPTH(NPAIR), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en_i  (cap_en),
    .cap_bit_i (race_win_i),
    .cap_ok_i  (race_valid_i),
    .pop_en_i  (pop_en),
    .word_o    (word_data_o),
    .mask_o    (word_mask_o)
  );

  assign race_go_o    = (state_q == ST_RACE);
  assign word_valid_o = (state_q == ST_OUTPUT);
  assign done_o       = done_q;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int SEL_W    = 4,
  parameter int WORD_W   = 16,
  parameter int SETTLE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [SETTLE_W-1:0]     settle_cycles_i,
  input logic [2*(1<<SEL_W)-1:0] osc_en_o,
  input logic                    race_go_o,
  input logic                    race_done_i,
  input logic                    word_valid_o,
  input logic                    word_ready_i,
  input logic [WORD_W-1:0]       word_data_o,
  input logic [WORD_W-1:0]       word_mask_o,
  input logic                    done_o
);
  localparam int GRP = 1 << SEL_W;

  logic [SETTLE_W+1:0] on_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       on_cnt_q <= '0;
    else if (osc_en_o == '0)          on_cnt_q <= '0;
    else if (!race_go_o)              on_cnt_q <= on_cnt_q + 1'b1;
  end

  p_pair_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_o != '0) |-> ($countones(osc_en_o[GRP-1:0]) == 1 &&
                          $countones(osc_en_o[2*GRP-1:GRP]) == 1));

  p_go_has_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    race_go_o |-> (osc_en_o != '0));

  p_settle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(race_go_o) |-> (on_cnt_q == ({2'b00, settle_cycles_i} + 2)));

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_o != '0 && $past(osc_en_o) != '0) |-> (osc_en_o == $past(osc_en_o)));

  p_race_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (race_go_o && race_done_i) |=> !race_go_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_mask_o)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !word_valid_o);

  p_quiet_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (osc_en_o == '0 && !race_go_o));
endmodule

bind pair_sweep_ctrl psc_checker #(
  .SEL_W    (SEL_W),
  .WORD_W   (WORD_W),
  .SETTLE_W (SETTLE_W)
) u_psc_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .settle_cycles_i (settle_cycles_i),
  .osc_en_o        (osc_en_o),
  .race_go_o       (race_go_o),
  .race_done_i     (race_done_i),
  .word_valid_o    (word_valid_o),
  .word_ready_i    (word_ready_i),
  .word_data_o     (word_data_o),
  .word_mask_o     (word_mask_o),
  .done_o          (done_o)
);

// File: tb/pair_sweep_ctrl_bench.sv
module pair_sweep_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  settle_cycles_i;
  logic [31:0] osc_en_o;
  logic        race_go_o;
  logic        race_done_i;
  logic        race_win_i;
  logic        race_valid_i;
  logic        word_valid_o;
  logic        word_ready_i;
  logic [15:0] word_data_o;
  logic [15:0] word_mask_o;
  logic        done_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] seed;

  // arbiter model bookkeeping
  int races, pair_err, settle_err, gap_err, order_err, en_cnt, lat;
  bit busy, saw_gap;

  // table: {settle, seed}; expected response follows from the seed
  localparam logic [15:0] VEC [0:3] = '{16'h005A, 16'h03C3, 16'h0100, 16'h071F};

  pair_sweep_ctrl u_pair_sweep_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
    .osc_en_o(osc_en_o), .race_go_o(race_go_o), .race_done_i(race_done_i),
    .race_win_i(race_win_i), .race_valid_i(race_valid_i), .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i), .word_data_o(word_data_o), .word_mask_o(word_mask_o),
    .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit exp_win(int c, logic [7:0] s);
    return (4'(c >> 4) ^ s[3:0]) > (4'(c) ^ s[7:4]);
  endfunction

  function automatic bit exp_vld(int c, logic [7:0] s);
    return (4'(c >> 4) ^ s[3:0]) != (4'(c) ^ s[7:4]);
  endfunction

  function automatic int first_set(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // arbiter model: answers each race from the identity of the enabled pair
  initial begin
    race_done_i = 1'b0; race_win_i = 1'b0; race_valid_i = 1'b0;
    busy = 0; saw_gap = 0; en_cnt = 0; lat = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        race_done_i = 1'b0; busy = 0; en_cnt = 0;
      end else begin
        if (race_done_i) race_done_i = 1'b0;
        if (osc_en_o == '0) begin saw_gap = 1; en_cnt = 0; end
        else begin
          if ($countones(osc_en_o[15:0]) != 1 || $countones(osc_en_o[31:16]) != 1)
            pair_err++;
          if (!race_go_o) en_cnt++;
        end
        if (race_go_o && !busy) begin
          int a, b, c;
          busy = 1;
          a = first_set(osc_en_o[15:0]);
          b = first_set(osc_en_o[31:16]);
          c = a * 16 + b;
          if (en_cnt != int'(settle_cycles_i) + 2) settle_err++;
          if (races > 0 && !saw_gap) gap_err++;
          if (c != races) order_err++;
          saw_gap = 0;
          races++;
          race_win_i   = exp_win(c, seed);
          race_valid_i = exp_vld(c, seed);
          lat = (a + b) % 3;
        end
        if (busy && race_go_o) begin
          if (lat == 0) race_done_i = 1'b1;
          else lat--;
        end
        if (!race_go_o) busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    start_i = 1'b0; word_ready_i = 1'b0; settle_cycles_i = 8'd0; seed = 8'h00;
    races = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(osc_en_o == 0 && !race_go_o && !word_valid_o && !done_o, "R1 reset state",
          {osc_en_o}, 0);

    for (int v = 0; v < 4; v++) begin
      settle_cycles_i = VEC[v][15:8];
      seed            = VEC[v][7:0];
      races = 0; pair_err = 0; settle_err = 0; gap_err = 0; order_err = 0;
      saw_gap = 0;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      while (races < 40 + v * 50) @(negedge clk);
      // R10: start pulse mid-sweep must not restart the order
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      while (!word_valid_o) @(negedge clk);
      check(races == 256, "R2 race count", races, 256);
      check(order_err == 0, "R2/R10 challenge order", order_err, 0);
      check(pair_err == 0, "R3 pair enables", pair_err, 0);
      check(settle_err == 0, "R4 settle length", settle_err, 0);
      check(gap_err == 0, "R5 gap between races", gap_err, 0);
      check(osc_en_o == 0 && !race_go_o, "R11 quiet while offering", osc_en_o, 0);
      for (int w = 0; w < 16; w++) begin
        logic [15:0] ed, em;
        bit stable;
        for (int k = 0; k < 16; k++) begin
          ed[k] = exp_win(w * 16 + k, seed);
          em[k] = exp_vld(w * 16 + k, seed);
        end
        check(word_valid_o && word_data_o == ed, "R6/R8 word data", word_data_o, ed);
        check(word_mask_o == em, "R7/R8 word mask", word_mask_o, em);
        stable = 1;
        for (int h = 0; h < v; h++) begin
          @(negedge clk);
          if (!word_valid_o || word_data_o != ed || word_mask_o != em) stable = 0;
        end
        if (v > 0) check(stable, "R8 hold without ready", stable, 1);
        word_ready_i = 1'b1;
        @(negedge clk);
        word_ready_i = 1'b0;
        if (w == 15) begin
          check(done_o == 1'b1 && !word_valid_o, "R9 done pulse", done_o, 1);
          @(negedge clk);
          check(done_o == 1'b0 && !word_valid_o, "R9 done one cycle", done_o, 0);
        end
      end
    end

    // R1: reset in the middle of a sweep returns to quiet idle
    settle_cycles_i = 8'd2; seed = 8'h33; races = 0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (races < 5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(osc_en_o == 0 && !race_go_o && !word_valid_o && !done_o, "R1 reset mid-sweep",
          osc_en_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(osc_en_o == 0 && !race_go_o && !word_valid_o, "R1 idle after reset",
          osc_en_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule